// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits beside the instruction sequencer of a small 8-bit processor. At each instruction boundary it decides whether an interrupt is taken. Four peripheral request lines feed it: vertical blank, display status, timer and keypad. The CPU also supplies an enable byte, its current program counter and its current stack pointer. The block owns the master interrupt enable and the halt flag.

When it dispatches, it performs these steps:
- It picks one source by fixed priority.
- It clears the master enable and acknowledges that source only.
- It pushes the return address onto a byte-wide stack over two consecutive write cycles.
- It presents the vector and the new stack pointer together with a dispatch-done pulse and a cost of 24 cycles.

Otherwise it reports either a 4-cycle halted idle boundary or a zero-cost pass that tells the CPU to fetch.

Wake from halt does not depend on the master enable. Any enabled and pending source releases the halt. Such a source is dispatched only when the master enable is set.

The controller is a Moore machine with six states:
- READY waits for `boundary_i`. On a boundary it goes to PUSH_HI when the master enable is set and a source is eligible. Otherwise it goes to SLEEP when halted with nothing eligible, and to RESUME in every other case.
- PUSH_HI writes the high byte and always moves to PUSH_LO.
- PUSH_LO writes the low byte and always moves to VECTOR.
- VECTOR pulses `done_o` and returns to READY.
- RESUME pulses `resume_o` and returns to READY.
- SLEEP pulses `sleep_o` and returns to READY.

Top module: `irq_dispatch`

## Requirements
- R1: Source i is eligible when its request line is high and its enable bit is set. The enable bits are 0 (vertical blank), 1 (display status), 2 (timer) and 4 (keypad). Bit 3 of `ie_i` has no effect on any source.
- R2: Among eligible sources, priority is vertical blank > display status > timer > keypad. Exactly one source is serviced per dispatch, and `ack_o` is at most one-hot.
- R3: With `done_o`, `pc_o` equals the vector: 0x40, 0x48, 0x50 or 0x60 for sources 0 to 3. `vec_idx_o` equals the vector divided by 8, which is 8, 9, 10 or 12.
- R4: On dispatch the master enable `ime_o` reads 0 from the first cycle after the boundary. `ack_o` pulses in that same cycle with only the serviced source's bit set (bit i = source i).
- R5: The first write after the boundary goes to address sp−1 with PC[15:8]. The next cycle writes address sp−2 with PC[7:0]. Arithmetic is modulo 2^16, and `sp_o` reads sp−2 with `done_o`.
- R6: `done_o`, with `pc_o` and `sp_o`, appears in the third cycle after the boundary. This is the cycle that follows both writes.
- R7: `cost_o` is 24 with `done_o`, 4 with `sleep_o` (halted, nothing eligible) and 0 with `resume_o`.
- R8: While halted, a boundary with an eligible source clears `halted_o`, even when the master enable is 0. In that case the boundary ends with `resume_o` and no write.
- R9: While halted with the master enable set, a boundary with an eligible source dispatches and clears `halted_o`.
- R10: With the master enable clear and not halted, a boundary never writes memory, never pulses `done_o` and never acknowledges. It ends with `resume_o`.
- R11: After reset, `ime_o`, `halted_o` and every strobe are 0. In READY without a boundary, `ime_set_i` sets the master enable, `ime_clr_i` clears it and `halt_i` sets the halt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe, one cycle |
| req_i | input | 4 | Pending requests: bit 0 vertical blank, 1 display status, 2 timer, 3 keypad |
| ie_i | input | 8 | Interrupt enable byte |
| ime_set_i | input | 1 | Set the master enable |
| ime_clr_i | input | 1 | Clear the master enable |
| halt_i | input | 1 | Enter the halt state |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Stack write address |
| mem_data_o | output | 8 | Stack write data |
| mem_we_o | output | 1 | Stack write strobe |
| ack_o | output | 4 | One-hot acknowledge of the serviced source |
| done_o | output | 1 | Dispatch-done pulse |
| vec_idx_o | output | 5 | Vector index (vector / 8) |
| pc_o | output | 16 | New program counter, valid with done_o |
| sp_o | output | 16 | New stack pointer, valid with done_o |
| resume_o | output | 1 | Boundary ended without dispatch; the CPU fetches |
| sleep_o | output | 1 | Boundary spent idle in halt |
| cost_o | output | 8 | Cycle cost of the reported boundary |
| ime_o | output | 1 | Master enable |
| halted_o | output | 1 | Halt flag |

## Verification
Several rules are checked on every cycle:
- `ack_o` is at most one-hot and coincides with the first write of a push.
- The two writes go to descending consecutive addresses.
- `done_o` only follows both writes and carries a legal vector with a cost of 24.
- Sleep boundaries cost 4.
- A masked, unhalted boundary never writes.
- An eligible source clears the halt flag.

Only the scenarios can show which source wins for a given mix of requests and enables, the exact bytes pushed, stack pointer wrap-around, and that enable bit 3 is ignored. They also show that pending flags of unserviced sources survive, and that the master enable and halt flag take the right values after each boundary.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VECTOR,
        ST_RESUME,
        ST_SLEEP
    } disp_state_t;

    // enable-byte bit used by source number src; bit 3 is skipped
    function automatic int unsigned mask_bit(input int unsigned src);
        return (src >= 3) ? src + 1 : src;
    endfunction

    // vector address divided by 8: 0x40 base plus 8 per enable bit
    function automatic logic [4:0] vec_index(input int unsigned src);
        return 5'(8 + mask_bit(src));
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_dispatch_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int IEW  = 8,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req_i,
    input  logic [IEW-1:0]  ie_i,
    output logic            any_o,
    output logic [IW-1:0]   win_o,
    output logic [NSRC-1:0] onehot_o
);

    logic [NSRC-1:0] elig;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_elig
            assign elig[g] = req_i[g] & ie_i[mask_bit(g)];
        end
    endgenerate

    // lowest index wins: scan downward so the last hit is the highest priority
    always_comb begin
        any_o    = |elig;
        win_o    = '0;
        onehot_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_o    = IW'(i);
                onehot_o = NSRC'(1) << i;
            end
        end
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic ime_set,
    input  logic ime_clr,
    input  logic halt_set,
    input  logic halt_clr,
    output logic ime_q,
    output logic halted_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ime_q <= 1'b0;
        end else if (ime_clr) begin
            ime_q <= 1'b0;
        end else if (ime_set) begin
            ime_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
        end else if (halt_clr) begin
            halted_q <= 1'b0;
        end else if (halt_set) begin
            halted_q <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int BW            = 8,
    parameter int NSRC          = 4,
    parameter int IEW           = 8,
    parameter int CW            = 8,
    parameter int COST_DISPATCH = 24,
    parameter int COST_SLEEP    = 4,
    localparam int AW           = 2 * BW,
    localparam int IW           = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary_i,
    input  logic [NSRC-1:0] req_i,
    input  logic [IEW-1:0]  ie_i,
    input  logic            ime_set_i,
    input  logic            ime_clr_i,
    input  logic            halt_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [AW-1:0]   sp_i,
    output logic [AW-1:0]   mem_addr_o,
    output logic [BW-1:0]   mem_data_o,
    output logic            mem_we_o,
    output logic [NSRC-1:0] ack_o,
    output logic            done_o,
    output logic [4:0]      vec_idx_o,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   sp_o,
    output logic            resume_o,
    output logic            sleep_o,
    output logic [CW-1:0]   cost_o,
    output logic            ime_o,
    output logic            halted_o
);

    disp_state_t     state_q, state_d;
    logic            any_elig;
    logic [IW-1:0]   win_idx;
    logic [NSRC-1:0] win_onehot;
    logic [IW-1:0]   src_q;
    logic [NSRC-1:0] src_onehot_q;
    logic [AW-1:0]   ret_pc_q;
    logic [AW-1:0]   sp_q;
    logic            take;
    logic            at_ready;
    logic [4:0]      idx_lut [NSRC];

    irq_arbiter #(.NSRC(NSRC), .IEW(IEW)) u_arb (
        .req_i    (req_i),
        .ie_i     (ie_i),
        .any_o    (any_elig),
        .win_o    (win_idx),
        .onehot_o (win_onehot)
    );

    assign at_ready = (state_q == ST_READY);
    assign take     = at_ready && boundary_i && ime_o && any_elig;

    irq_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ime_set  (at_ready && !boundary_i && ime_set_i),
        .ime_clr  (take || (at_ready && !boundary_i && ime_clr_i)),
        .halt_set (at_ready && !boundary_i && halt_i),
        .halt_clr (at_ready && boundary_i && any_elig),
        .ime_q    (ime_o),
        .halted_q (halted_o)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_lut
            assign idx_lut[g] = vec_index(g);
        end
    endgenerate

    // state register and dispatch context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_READY;
            src_q        <= '0;
            src_onehot_q <= '0;
            ret_pc_q     <= '0;
            sp_q         <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                src_q        <= win_idx;
                src_onehot_q <= win_onehot;
                ret_pc_q     <= pc_i;
                sp_q         <= sp_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (boundary_i) begin
                    if (ime_o && any_elig) begin
                        state_d = ST_PUSH_HI;
                    end else if (halted_o && !any_elig) begin
                        state_d = ST_SLEEP;
                    end else begin
                        state_d = ST_RESUME;
                    end
                end
            end
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_READY;
            ST_RESUME:  state_d = ST_READY;
            ST_SLEEP:   state_d = ST_READY;
            default:    state_d = ST_READY;
        endcase
    end

    // Moore outputs
    always_comb begin
        mem_addr_o = '0;
        mem_data_o = '0;
        mem_we_o   = 1'b0;
        ack_o      = '0;
        done_o     = 1'b0;
        vec_idx_o  = '0;
        pc_o       = '0;
        sp_o       = '0;
        resume_o   = 1'b0;
        sleep_o    = 1'b0;
        cost_o     = '0;
        unique case (state_q)
            ST_READY: ;
            ST_PUSH_HI: begin
                mem_we_o   = 1'b1;
                mem_addr_o = sp_q - AW'(1);
                mem_data_o = ret_pc_q[AW-1:BW];
                ack_o      = src_onehot_q;
            end
            ST_PUSH_LO: begin
                mem_we_o   = 1'b1;
                mem_addr_o = sp_q - AW'(2);
                mem_data_o = ret_pc_q[BW-1:0];
            end
            ST_VECTOR: begin
                done_o    = 1'b1;
                vec_idx_o = idx_lut[src_q];
                pc_o      = AW'({idx_lut[src_q], 3'b000});
                sp_o      = sp_q - AW'(2);
                cost_o    = CW'(COST_DISPATCH);
            end
            ST_RESUME: begin
                resume_o = 1'b1;
            end
            ST_SLEEP: begin
                sleep_o = 1'b1;
                cost_o  = CW'(COST_SLEEP);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
    import irq_dispatch_pkg::*;
#(
    parameter int BW            = 8,
    parameter int NSRC          = 4,
    parameter int IEW           = 8,
    parameter int CW            = 8,
    parameter int COST_DISPATCH = 24,
    parameter int COST_SLEEP    = 4,
    localparam int AW           = 2 * BW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boundary_i,
    input logic [NSRC-1:0] req_i,
    input logic [IEW-1:0]  ie_i,
    input logic [AW-1:0]   mem_addr_o,
    input logic            mem_we_o,
    input logic [NSRC-1:0] ack_o,
    input logic            done_o,
    input logic [4:0]      vec_idx_o,
    input logic [AW-1:0]   pc_o,
    input logic            resume_o,
    input logic            sleep_o,
    input logic [CW-1:0]   cost_o,
    input logic            ime_o,
    input logic            halted_o,
    input disp_state_t     state_q
);

    logic [NSRC-1:0] elig_c;
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig_c[i] = req_i[i] & ie_i[mask_bit(i)];
        end
    end

    p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    p_ack_first_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (mem_we_o && !ime_o));

    p_push_descend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !$past(mem_we_o)) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - AW'(1)));

    p_done_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_we_o) && !mem_we_o));

    p_vector_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pc_o == AW'({vec_idx_o, 3'b000}) && vec_idx_o >= 5'd8 && vec_idx_o <= 5'd12 && vec_idx_o != 5'd11));

    p_cost_dispatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cost_o == CW'(COST_DISPATCH));

    p_cost_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> cost_o == CW'(COST_SLEEP));

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && boundary_i && !ime_o && !halted_o) |=> (resume_o && !mem_we_o && ack_o == '0));

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && boundary_i && halted_o && (|elig_c)) |=> !halted_o);

endmodule

bind irq_dispatch irq_dispatch_chk #(
    .BW(BW), .NSRC(NSRC), .IEW(IEW), .CW(CW),
    .COST_DISPATCH(COST_DISPATCH), .COST_SLEEP(COST_SLEEP)
) u_chk (.*);

// File: tb/irq_dispatch_test.sv
`timescale 1ns/1ps
module irq_dispatch_test;

    typedef enum int {EV_WRITE, EV_DONE, EV_RESUME, EV_SLEEP} ev_t;
    typedef struct {
        ev_t         kind;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [3:0]  ack;
        logic [4:0]  vec;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  cost;
        int          tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic [7:0]  ie_i = '0;
    logic        ime_set_i = 1'b0, ime_clr_i = 1'b0, halt_i = 1'b0;
    logic [15:0] pc_i = '0, sp_i = '0;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_o;
    logic        mem_we_o;
    logic [3:0]  ack_o;
    logic        done_o;
    logic [4:0]  vec_idx_o;
    logic [15:0] pc_o, sp_o;
    logic        resume_o, sleep_o;
    logic [7:0]  cost_o;
    logic        ime_o, halted_o;

    // peripheral stub: pending flags cleared by acknowledge
    logic [3:0]  pend = '0;
    logic        load = 1'b0;
    logic [3:0]  load_val = '0;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    ime_m = 0, halted_m = 0;
    bit    finished = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (load) pend <= load_val;
        else      pend <= pend & ~ack_o;
    end

    irq_dispatch uut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_i(pend), .ie_i(ie_i),
        .ime_set_i(ime_set_i), .ime_clr_i(ime_clr_i), .halt_i(halt_i),
        .pc_i(pc_i), .sp_i(sp_i), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .mem_we_o(mem_we_o), .ack_o(ack_o), .done_o(done_o), .vec_idx_o(vec_idx_o),
        .pc_o(pc_o), .sp_o(sp_o), .resume_o(resume_o), .sleep_o(sleep_o),
        .cost_o(cost_o), .ime_o(ime_o), .halted_o(halted_o)
    );

    task automatic cmp(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pop the scoreboard whenever the design reports an event
    always @(negedge clk) begin
        if (rst_n && (mem_we_o || done_o || resume_o || sleep_o)) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R10 unexpected event: actual we%0b done%0b res%0b slp%0b expected none",
                         mem_we_o, done_o, resume_o, sleep_o);
            end else begin
                item_t it;
                ev_t   got;
                it  = exp_q.pop_front();
                got = mem_we_o ? EV_WRITE : done_o ? EV_DONE : resume_o ? EV_RESUME : EV_SLEEP;
                cmp(it.tag, "event kind", 32'(int'(got)), 32'(int'(it.kind)));
                case (it.kind)
                    EV_WRITE: begin  // R5 push bytes, R4 acknowledge
                        cmp(5, "write addr", 32'(mem_addr_o), 32'(it.addr));
                        cmp(5, "write data", 32'(mem_data_o), 32'(it.data));
                        cmp(4, "ack", 32'(ack_o), 32'(it.ack));
                    end
                    EV_DONE: begin   // R3 vector, R6 timing, R7 cost
                        cmp(3, "vec idx", 32'(vec_idx_o), 32'(it.vec));
                        cmp(3, "new pc", 32'(pc_o), 32'(it.pc));
                        cmp(5, "new sp", 32'(sp_o), 32'(it.sp));
                        cmp(7, "dispatch cost", 32'(cost_o), 32'(it.cost));
                    end
                    default: begin   // R7 idle/pass cost
                        cmp(7, "cost", 32'(cost_o), 32'(it.cost));
                    end
                endcase
            end
        end
    end

    task automatic push_item(input ev_t k, input logic [15:0] a, input logic [7:0] d, input logic [3:0] ak,
                             input logic [4:0] v, input logic [15:0] p, input logic [15:0] s,
                             input logic [7:0] c, input int tag);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.ack = ak; it.vec = v;
        it.pc = p; it.sp = s; it.cost = c; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic set_ime();
        @(negedge clk); ime_set_i = 1'b1;
        @(negedge clk); ime_set_i = 1'b0;
        ime_m = 1;
        cmp(11, "ime after set", 32'(ime_o), 32'(1));  // R11
    endtask

    task automatic clr_ime();
        @(negedge clk); ime_clr_i = 1'b1;
        @(negedge clk); ime_clr_i = 1'b0;
        ime_m = 0;
        cmp(11, "ime after clear", 32'(ime_o), 32'(0)); // R11
    endtask

    task automatic do_halt();
        @(negedge clk); halt_i = 1'b1;
        @(negedge clk); halt_i = 1'b0;
        halted_m = 1;
        cmp(11, "halted after halt", 32'(halted_o), 32'(1)); // R11
    endtask

    // driver: compute expectations from the requirements, then run one boundary
    task automatic step(input logic [3:0] req, input logic [7:0] ie, input logic [15:0] pc,
                        input logic [15:0] sp, input int tag);
        logic [3:0] elig;
        logic [3:0] pend_exp;
        logic [4:0] idx;
        int         win;
        elig = {req[3] & ie[4], req[2] & ie[2], req[1] & ie[1], req[0] & ie[0]}; // R1
        win = -1;
        for (int i = 3; i >= 0; i--) if (elig[i]) win = i;                        // R2
        pend_exp = req;
        if (ime_m && win >= 0) begin
            idx = (win == 3) ? 5'd12 : 5'(8 + win);                               // R3
            push_item(EV_WRITE, sp - 16'd1, pc[15:8], 4'(1 << win), '0, '0, '0, '0, tag);
            push_item(EV_WRITE, sp - 16'd2, pc[7:0], 4'b0, '0, '0, '0, '0, tag);
            push_item(EV_DONE, '0, '0, '0, idx, {8'h00, idx, 3'b000}, sp - 16'd2, 8'd24, tag);
            ime_m = 0;
            halted_m = 0;                                                         // R9
            pend_exp = req & ~4'(1 << win);
        end else if (halted_m && elig == 4'b0) begin
            push_item(EV_SLEEP, '0, '0, '0, '0, '0, '0, 8'd4, tag);              // R7
        end else begin
            push_item(EV_RESUME, '0, '0, '0, '0, '0, '0, 8'd0, tag);             // R8 R10
            halted_m = 0;
        end
        @(negedge clk);
        load = 1'b1; load_val = req; ie_i = ie; pc_i = pc; sp_i = sp;
        @(negedge clk);
        load = 1'b0; boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        repeat (5) @(negedge clk);
        cmp(tag, "ime after boundary", 32'(ime_o), 32'(ime_m));
        cmp(tag, "halted after boundary", 32'(halted_o), 32'(halted_m));
        cmp(tag, "pending flags", 32'(pend), 32'(pend_exp));
        cmp(tag, "scoreboard drained", 32'(exp_q.size()), 32'(0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        cmp(11, "reset strobes", 32'({mem_we_o, done_o, resume_o, sleep_o, ack_o}), 32'(0));
        cmp(11, "reset ime/halt", 32'({ime_o, halted_o}), 32'(0));

        set_ime();
        step(4'b1111, 8'hFF, 16'h1234, 16'hFFFE, 2);  // R2: vertical blank wins
        set_ime();
        step(4'b1110, 8'h16, 16'hABCD, 16'hC000, 2);  // R2: display status over timer/keypad
        set_ime();
        step(4'b1111, 8'h08, 16'h0200, 16'hD000, 1);  // R1: bit 3 enables nothing
        step(4'b1000, 8'h10, 16'h5A6B, 16'h0001, 5);  // R5: keypad, stack wraps; R3 vector 0x60
        set_ime();
        step(4'b1100, 8'h14, 16'h0150, 16'hFFF0, 3);  // R3: timer 0x50
        clr_ime();
        step(4'b0001, 8'h01, 16'h0300, 16'hE000, 10); // R10: masked, no write
        do_halt();
        step(4'b0001, 8'h00, 16'h0300, 16'hE000, 7);  // R7: halted idle costs 4
        step(4'b0100, 8'h04, 16'h0300, 16'hE000, 8);  // R8: wake without master enable
        set_ime();
        do_halt();
        step(4'b0010, 8'h02, 16'h4000, 16'h8000, 9);  // R9: dispatch from halt; R6 ordering

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule